// File: doc/BRIEF.md
# Clock Request Output Gating

This block decides, for every differential clock output of a clock generator, whether that output runs or is stopped. When an output is stopped, the block also decides whether the pin is driven low or left floating. There are three groups of outputs: PCIe reference outputs, CPU outputs and graphics outputs.

Each PCIe reference output has a master enable. Two bits let either of two active-low request pins (A and B) control the output. The graphics outputs follow only their own enables. Each CPU output has an enable and a stoppable bit, and the stoppable bit makes the output respond to an active-low CPU stop pin. One mode bit selects what a stopped output does: 0 drives it low, 1 floats it.

All control inputs are treated as asynchronous. They pass through a two-flop synchronizer clocked by the rising edge of the output clock. The resulting decisions are loaded on a falling edge, while the clock is low, so an output never starts or stops in the middle of a high phase.

Top module: `clkreq_gate`

## Requirements
- R1: While `rst` is high, every run, float and conflict output is 0 at each falling edge, whatever the inputs.
- R2: A PCIe reference output whose master enable is 0 is stopped, whatever the state of either request pin or of its mapping bits.
- R3: A PCIe reference output with its A-mapping bit set and its B-mapping bit clear runs when `req_a_n` is 0 and stops when `req_a_n` is 1 (request deasserted). An output with neither mapping bit set ignores both request pins.
- R4: A PCIe reference output with its B-mapping bit set and its A-mapping bit clear runs when `req_b_n` is 0 and stops when `req_b_n` is 1. Its A-mapping state and `req_a_n` have no effect on it.
- R5: If both mapping bits of a PCIe reference output are set, that output is stopped and its bit in `src_map_conflict` is 1. The conflict bit of every other output stays 0, and it returns to 0 once the mapping is made legal.
- R6: A graphics output runs exactly when its enable bit is 1. Request pins, mapping bits and the CPU stop pin have no effect on it.
- R7: A CPU output with its enable at 1 stops while `cpu_stop_n` is 0 if its stoppable bit is 1. If its stoppable bit is 0, it keeps running while `cpu_stop_n` is 0.
- R8: A CPU output with its enable bit at 0 is stopped, whatever the stop pin.
- R9: With `float_off` at 1, every stopped output has its float bit at 1. With `float_off` at 0, every float bit is 0. A running output never has its float bit set.
- R10: A change made to an input just after a falling edge does not appear at the outputs at the next falling edge, nor in the high phase that follows it. It appears at the second falling edge. Outputs change only at falling edges of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock; synchronizer on the rising edge, decisions loaded on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| src_master_en | input | N_SRC | Master enable per PCIe reference output |
| src_map_a | input | N_SRC | 1 = request pin A controls this PCIe reference output |
| src_map_b | input | N_SRC | 1 = request pin B controls this PCIe reference output |
| cpu_en | input | N_CPU | Enable per CPU output |
| cpu_stoppable | input | N_CPU | 1 = CPU output stops while `cpu_stop_n` is 0 |
| gfx_en | input | N_GFX | Enable per graphics output |
| req_a_n | input | 1 | Request pin A, active low |
| req_b_n | input | 1 | Request pin B, active low |
| cpu_stop_n | input | 1 | CPU stop pin, active low |
| float_off | input | 1 | 0 = stopped outputs driven low, 1 = stopped outputs floated |
| src_run | output | N_SRC | Run decision per PCIe reference output |
| src_float | output | N_SRC | Float control per PCIe reference output |
| src_map_conflict | output | N_SRC | 1 = both request mappings set on this output |
| cpu_run | output | N_CPU | Run decision per CPU output |
| cpu_float | output | N_CPU | Float control per CPU output |
| gfx_run | output | N_GFX | Run decision per graphics output |
| gfx_float | output | N_GFX | Float control per graphics output |

## Verification
The PCIe reference gating is driven with mixed enable masks, with A-only, B-only and dual mappings on different outputs, and with each request pin held both asserted and deasserted. These patterns separate a stop caused by a pin from a stop caused by the master enable, and they show that one output's conflict does not spread to its neighbours. The CPU patterns combine the stop pin with a stoppable mask and with an enable mask, which separates free-running outputs from stoppable ones. Float masks are compared against run masks under both settings of the mode bit. A timed scenario samples the outputs after the first falling edge, in the high phase that follows, and after the second falling edge. This shows both the two-flop latency and that outputs change only on the falling edge.

// File: rtl/crq_pkg.sv
package crq_pkg;

    typedef enum logic {
        OFF_DRIVEN = 1'b0,
        OFF_FLOAT  = 1'b1
    } off_mode_e;

    typedef struct packed {
        logic en;
        logic map_a;
        logic map_b;
    } src_cfg_t;

    typedef struct packed {
        logic run;
        logic conflict;
    } src_verdict_t;

    // A request pin that is high means the request is withdrawn, so a
    // mapped output stops. A dual mapping always forces the output off.
    function automatic src_verdict_t src_decide(input src_cfg_t c,
                                                input logic a_stop,
                                                input logic b_stop);
        src_verdict_t v;
        v.conflict = c.map_a & c.map_b;
        v.run      = c.en & ~v.conflict
                   & ~(c.map_a & a_stop)
                   & ~(c.map_b & b_stop);
        return v;
    endfunction

    function automatic logic cpu_decide(input logic en,
                                        input logic stoppable,
                                        input logic stop_active);
        return en & ~(stoppable & stop_active);
    endfunction

    function automatic logic float_of(input logic run, input off_mode_e mode);
        return (mode == OFF_FLOAT) & ~run;
    endfunction

endpackage

// File: rtl/crq_sync.sv
module crq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/crq_decide.sv
module crq_decide
    import crq_pkg::*;
#(
    parameter int N_SRC = 6,
    parameter int N_CPU = 3,
    parameter int N_GFX = 2
) (
    input  logic [N_SRC-1:0] src_en,
    input  logic [N_SRC-1:0] map_a,
    input  logic [N_SRC-1:0] map_b,
    input  logic [N_CPU-1:0] cpu_en,
    input  logic [N_CPU-1:0] cpu_stoppable,
    input  logic [N_GFX-1:0] gfx_en,
    input  logic             a_stop,
    input  logic             b_stop,
    input  logic             cpu_stop_act,
    output logic [N_SRC-1:0] src_run_d,
    output logic [N_SRC-1:0] src_conflict_d,
    output logic [N_CPU-1:0] cpu_run_d,
    output logic [N_GFX-1:0] gfx_run_d
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        src_cfg_t     cfg;
        src_verdict_t verdict;
        assign cfg.en             = src_en[i];
        assign cfg.map_a          = map_a[i];
        assign cfg.map_b          = map_b[i];
        assign verdict            = src_decide(cfg, a_stop, b_stop);
        assign src_run_d[i]       = verdict.run;
        assign src_conflict_d[i]  = verdict.conflict;
    end

    for (genvar j = 0; j < N_CPU; j++) begin : g_cpu
        assign cpu_run_d[j] = cpu_decide(cpu_en[j], cpu_stoppable[j], cpu_stop_act);
    end

    // Graphics outputs follow their enables only.
    assign gfx_run_d = gfx_en;
endmodule

// File: rtl/crq_gate.sv
module crq_gate
    import crq_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] run_d,
    input  logic         float_off,
    output logic [W-1:0] run_q,
    output logic [W-1:0] float_q
);
    off_mode_e mode;
    assign mode = float_off ? OFF_FLOAT : OFF_DRIVEN;

    // Loaded while the clock is low, so no output is cut mid high phase.
    always_ff @(negedge clk) begin
        if (rst) begin
            run_q   <= '0;
            float_q <= '0;
        end else begin
            run_q <= run_d;
            for (int i = 0; i < W; i++) begin
                float_q[i] <= float_of(run_d[i], mode);
            end
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_chk
        // R9
        float_needs_stop_chk: assert property (@(posedge clk) disable iff (rst)
            float_q[i] |-> !run_q[i]);
    end
endmodule

// File: rtl/clkreq_gate.sv
module clkreq_gate
    import crq_pkg::*;
#(
    parameter int N_SRC = 6,
    parameter int N_CPU = 3,
    parameter int N_GFX = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_master_en,
    input  logic [N_SRC-1:0] src_map_a,
    input  logic [N_SRC-1:0] src_map_b,
    input  logic [N_CPU-1:0] cpu_en,
    input  logic [N_CPU-1:0] cpu_stoppable,
    input  logic [N_GFX-1:0] gfx_en,
    input  logic             req_a_n,
    input  logic             req_b_n,
    input  logic             cpu_stop_n,
    input  logic             float_off,
    output logic [N_SRC-1:0] src_run,
    output logic [N_SRC-1:0] src_float,
    output logic [N_SRC-1:0] src_map_conflict,
    output logic [N_CPU-1:0] cpu_run,
    output logic [N_CPU-1:0] cpu_float,
    output logic [N_GFX-1:0] gfx_run,
    output logic [N_GFX-1:0] gfx_float
);
    localparam int EN_LO    = 0;
    localparam int MAPA_LO  = EN_LO + N_SRC;
    localparam int MAPB_LO  = MAPA_LO + N_SRC;
    localparam int CEN_LO   = MAPB_LO + N_SRC;
    localparam int CSTP_LO  = CEN_LO + N_CPU;
    localparam int GFX_LO   = CSTP_LO + N_CPU;
    localparam int PIN_LO   = GFX_LO + N_GFX;
    localparam int BUS_W    = PIN_LO + 4;

    logic [BUS_W-1:0] async_bus, sync_bus;

    assign async_bus = {float_off, cpu_stop_n, req_b_n, req_a_n, gfx_en,
                        cpu_stoppable, cpu_en, src_map_b, src_map_a, src_master_en};

    crq_sync #(.W(BUS_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (async_bus),
        .q   (sync_bus)
    );

    logic [N_SRC-1:0] en_s, map_a_s, map_b_s;
    logic [N_CPU-1:0] cen_s, cstp_s;
    logic [N_GFX-1:0] gfx_s;
    logic             req_a_s, req_b_s, stop_n_s, float_s;

    assign en_s     = sync_bus[EN_LO   +: N_SRC];
    assign map_a_s  = sync_bus[MAPA_LO +: N_SRC];
    assign map_b_s  = sync_bus[MAPB_LO +: N_SRC];
    assign cen_s    = sync_bus[CEN_LO  +: N_CPU];
    assign cstp_s   = sync_bus[CSTP_LO +: N_CPU];
    assign gfx_s    = sync_bus[GFX_LO  +: N_GFX];
    assign req_a_s  = sync_bus[PIN_LO];
    assign req_b_s  = sync_bus[PIN_LO + 1];
    assign stop_n_s = sync_bus[PIN_LO + 2];
    assign float_s  = sync_bus[PIN_LO + 3];

    logic [N_SRC-1:0] src_run_d, src_conflict_d;
    logic [N_CPU-1:0] cpu_run_d;
    logic [N_GFX-1:0] gfx_run_d;

    crq_decide #(.N_SRC(N_SRC), .N_CPU(N_CPU), .N_GFX(N_GFX)) u_decide (
        .src_en         (en_s),
        .map_a          (map_a_s),
        .map_b          (map_b_s),
        .cpu_en         (cen_s),
        .cpu_stoppable  (cstp_s),
        .gfx_en         (gfx_s),
        .a_stop         (req_a_s),
        .b_stop         (req_b_s),
        .cpu_stop_act   (~stop_n_s),
        .src_run_d      (src_run_d),
        .src_conflict_d (src_conflict_d),
        .cpu_run_d      (cpu_run_d),
        .gfx_run_d      (gfx_run_d)
    );

    crq_gate #(.W(N_SRC)) u_gate_src (
        .clk (clk), .rst (rst), .run_d (src_run_d), .float_off (float_s),
        .run_q (src_run), .float_q (src_float)
    );

    crq_gate #(.W(N_CPU)) u_gate_cpu (
        .clk (clk), .rst (rst), .run_d (cpu_run_d), .float_off (float_s),
        .run_q (cpu_run), .float_q (cpu_float)
    );

    crq_gate #(.W(N_GFX)) u_gate_gfx (
        .clk (clk), .rst (rst), .run_d (gfx_run_d), .float_off (float_s),
        .run_q (gfx_run), .float_q (gfx_float)
    );

    always_ff @(negedge clk) begin
        if (rst) src_map_conflict <= '0;
        else     src_map_conflict <= src_conflict_d;
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_src_chk
        // R2
        src_master_off_chk: assert property (@(posedge clk) disable iff (rst)
            !en_s[i] |-> !src_run[i]);
        // R5
        conflict_forces_off_chk: assert property (@(posedge clk) disable iff (rst)
            src_map_conflict[i] |-> !src_run[i]);
        // R5
        conflict_flag_chk: assert property (@(posedge clk) disable iff (rst)
            (map_a_s[i] && map_b_s[i]) |-> src_map_conflict[i]);
    end

    for (genvar j = 0; j < N_CPU; j++) begin : g_cpu_chk
        // R7
        cpu_stop_chk: assert property (@(posedge clk) disable iff (rst)
            (cstp_s[j] && !stop_n_s) |-> !cpu_run[j]);
        // R8
        cpu_en_off_chk: assert property (@(posedge clk) disable iff (rst)
            !cen_s[j] |-> !cpu_run[j]);
    end

    for (genvar k = 0; k < N_GFX; k++) begin : g_gfx_chk
        // R6
        gfx_follow_chk: assert property (@(posedge clk) disable iff (rst)
            gfx_run[k] == gfx_s[k]);
    end
endmodule

// File: tb/clkreq_gate_bench.sv
`timescale 1ns/1ps
module clkreq_gate_bench;
    localparam int N_SRC = 6;
    localparam int N_CPU = 3;
    localparam int N_GFX = 2;

    logic clk = 1'b0;
    logic rst;
    logic [N_SRC-1:0] src_master_en, src_map_a, src_map_b;
    logic [N_CPU-1:0] cpu_en, cpu_stoppable;
    logic [N_GFX-1:0] gfx_en;
    logic req_a_n, req_b_n, cpu_stop_n, float_off;
    logic [N_SRC-1:0] src_run, src_float, src_map_conflict;
    logic [N_CPU-1:0] cpu_run, cpu_float;
    logic [N_GFX-1:0] gfx_run, gfx_float;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    clkreq_gate #(.N_SRC(N_SRC), .N_CPU(N_CPU), .N_GFX(N_GFX)) u_clkreq_gate (
        .clk (clk), .rst (rst),
        .src_master_en (src_master_en), .src_map_a (src_map_a), .src_map_b (src_map_b),
        .cpu_en (cpu_en), .cpu_stoppable (cpu_stoppable), .gfx_en (gfx_en),
        .req_a_n (req_a_n), .req_b_n (req_b_n), .cpu_stop_n (cpu_stop_n),
        .float_off (float_off),
        .src_run (src_run), .src_float (src_float), .src_map_conflict (src_map_conflict),
        .cpu_run (cpu_run), .cpu_float (cpu_float),
        .gfx_run (gfx_run), .gfx_float (gfx_float)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Inputs change just after a falling edge; outputs reflect them
    // after the second falling edge that follows.
    task automatic settle();
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic drive_defaults();
        src_master_en = '1; src_map_a = '0; src_map_b = '0;
        cpu_en = '1; cpu_stoppable = '0; gfx_en = '1;
        req_a_n = 1'b1; req_b_n = 1'b1; cpu_stop_n = 1'b1; float_off = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        drive_defaults();
        float_off = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        chk("R1 src_run in reset", src_run, 0);
        chk("R1 cpu_run in reset", cpu_run, 0);
        chk("R1 gfx_run in reset", gfx_run, 0);
        chk("R1 float in reset", {src_float, cpu_float, gfx_float}, 0);
        chk("R1 conflict in reset", src_map_conflict, 0);
        rst = 1'b0;
        float_off = 1'b0;
        settle();
    endtask

    task automatic t_unmapped();
        drive_defaults();
        settle();
        chk("R3 unmapped, pins high", src_run, 6'h3F);
        req_a_n = 1'b0; req_b_n = 1'b0;
        settle();
        chk("R3 unmapped, pins low", src_run, 6'h3F);
    endtask

    task automatic t_master();
        drive_defaults();
        src_master_en = 6'b101010; req_a_n = 1'b0; req_b_n = 1'b0;
        settle();
        chk("R2 master mask, pins asserted", src_run, 6'b101010);
        chk("R9 driven mode float clear", src_float, 0);
        src_map_a = 6'b000001; src_master_en = 6'b101010;
        settle();
        chk("R2 master off overrides mapped asserted pin", src_run[0], 0);
    endtask

    task automatic t_map_a();
        drive_defaults();
        src_map_a = 6'b000011;
        settle();
        chk("R3 A deasserted stops mapped", src_run, 6'b111100);
        req_a_n = 1'b0;
        settle();
        chk("R3 A asserted runs mapped", src_run, 6'h3F);
        req_b_n = 1'b1;
        settle();
        chk("R3 B pin ignored for A-mapped", src_run, 6'h3F);
    endtask

    task automatic t_map_b();
        drive_defaults();
        src_map_b = 6'b110000; req_a_n = 1'b0;
        settle();
        chk("R4 B deasserted stops mapped", src_run, 6'b001111);
        req_b_n = 1'b0; req_a_n = 1'b1;
        settle();
        chk("R4 B asserted runs, A ignored", src_run, 6'h3F);
    endtask

    task automatic t_conflict();
        drive_defaults();
        src_map_a = 6'b000100; src_map_b = 6'b000100;
        req_a_n = 1'b0; req_b_n = 1'b0;
        settle();
        chk("R5 dual map forced off", src_run, 6'b111011);
        chk("R5 conflict flag only on that output", src_map_conflict, 6'b000100);
        src_map_b = '0;
        settle();
        chk("R5 conflict clears", src_map_conflict, 0);
        chk("R5 output recovers", src_run, 6'h3F);
    endtask

    task automatic t_gfx();
        drive_defaults();
        gfx_en = 2'b01; src_map_a = '1; cpu_stop_n = 1'b0;
        settle();
        chk("R6 gfx follows enable, pins high", gfx_run, 2'b01);
        gfx_en = 2'b10; req_a_n = 1'b0;
        settle();
        chk("R6 gfx follows enable, pins low", gfx_run, 2'b10);
    endtask

    task automatic t_cpu();
        drive_defaults();
        cpu_stoppable = 3'b011; cpu_stop_n = 1'b0;
        settle();
        chk("R7 stoppable outputs stop", cpu_run, 3'b100);
        cpu_stop_n = 1'b1;
        settle();
        chk("R7 stop released", cpu_run, 3'b111);
        cpu_en = 3'b110; cpu_stoppable = 3'b000; cpu_stop_n = 1'b0;
        settle();
        chk("R8 disabled cpu off", cpu_run, 3'b110);
    endtask

    task automatic t_float();
        drive_defaults();
        float_off = 1'b1; src_master_en = 6'b000111; cpu_en = 3'b011; gfx_en = 2'b01;
        settle();
        chk("R9 src float on stopped", src_float, 6'b111000);
        chk("R9 cpu float on stopped", cpu_float, 3'b100);
        chk("R9 gfx float on stopped", gfx_float, 2'b10);
        float_off = 1'b0;
        settle();
        chk("R9 driven mode clears float", {src_float, cpu_float, gfx_float}, 0);
    endtask

    task automatic t_latency();
        drive_defaults();
        settle();
        src_master_en = '0;
        @(negedge clk); #1;
        chk("R10 unchanged after first falling edge", src_run, 6'h3F);
        @(posedge clk); #1;
        chk("R10 unchanged in high phase", src_run, 6'h3F);
        @(negedge clk); #1;
        chk("R10 changed at second falling edge", src_run, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive_defaults();
        @(negedge clk); #1;
        t_reset();
        t_unmapped();
        t_master();
        t_map_a();
        t_map_b();
        t_conflict();
        t_gfx();
        t_cpu();
        t_float();
        t_latency();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule